// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block is the command front end of a byte-wide NOR flash, written as synchronous logic. The host presents write cycles as a one-clock strobe with address and data already captured. The block decodes these into one-cycle and two-cycle command sequences. It keeps a read mode that decides what the read port returns: array bytes forwarded from an external memory port, a pair of identifier bytes, or an 8-bit status byte.

Program and erase algorithms run in a separate automation engine. This block asks that engine to start, suspend or resume, and the engine reports back with completion, failure and suspend-acknowledge pulses. The block owns the sticky error bits of the status byte, and a single input bit models whether the programming supply is adequate. The write port has no back-pressure: every strobe is taken in the cycle it is presented. Commands that are not valid in the current state are dropped silently. The engine pulses are plain control pins.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While reset is low and after it is released, the read mode is array, no operation is active, and the status byte reads 80h. The status layout is: bit 7 ready, bit 6 suspended, bit 5 erase error, bit 4 write error, bit 3 supply-low, and bits 2..0 always 0.
- R2: A strobe with data FFh selects array mode, in which rd_data equals mem_rdata. Data 70h selects status mode, in which rd_data is the status byte.
- R3: After 90h, a read at address 0 returns 89h, a read at address 1 returns A2h, and any other address returns 00h.
- R4: Setup code 40h or 10h followed by a second strobe starts a byte write. One cycle after the second strobe, eng_start is high for exactly one cycle with eng_erase=0, and eng_addr and eng_wdata hold that strobe's address and data. The mode becomes status and ready drops.
- R5: Setup code 20h followed by D0h starts an erase (eng_erase=1, eng_addr = the confirm address). Any other byte after 20h starts nothing, sets bits 5 and 4, and selects status mode.
- R6: While a byte write runs, only 70h has an effect. All other codes leave the mode and status unchanged.
- R7: While an erase runs, B0h raises eng_suspend for one cycle and selects status mode. Bits 6 and 7 rise when eng_susp_ack arrives, and FFh and other codes except 70h are ignored.
- R8: While suspended, FFh, 70h and D0h are the only valid codes. D0h pulses eng_resume, clears bit 6, drops ready and selects status mode.
- R9: An eng_done pulse ends the operation and sets ready. If eng_fail is high with it, the pulse sets bit 5 for an erase or bit 4 for a byte write.
- R10: Bits 5..3 stay set through any number of later commands and operations until 50h, which clears all three and leaves the mode unchanged.
- R11: A start attempted with vpp_ok low sets bit 3 and starts nothing. While bit 3 is set, every start is refused even with vpp_ok high.
- R12: Reserved codes leave the mode unchanged and set no status bit.
- R13: The ready output equals status bit 7: high when idle or suspended, low while an operation runs or a suspend is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_addr | input | AW | Write cycle address |
| wr_data | input | 8 | Write cycle data / command byte |
| rd_addr | input | AW | Read address (identifier select) |
| rd_data | output | 8 | Read data per current mode |
| mem_rdata | input | 8 | Array byte from external memory port |
| vpp_ok | input | 1 | Programming supply adequate |
| ready | output | 1 | High when idle or suspended |
| eng_start | output | 1 | One-cycle start request to engine |
| eng_erase | output | 1 | Operation kind: 1 erase, 0 byte write |
| eng_addr | output | AW | Target address for the engine |
| eng_wdata | output | 8 | Byte to program |
| eng_suspend | output | 1 | One-cycle suspend request |
| eng_resume | output | 1 | One-cycle resume request |
| eng_done | input | 1 | Engine completion pulse |
| eng_fail | input | 1 | Failure flag, valid with eng_done |
| eng_susp_ack | input | 1 | Engine has parked the erase |

## Verification
A strobe or engine pulse sampled at clock edge N changes the registered mode and status at that edge. rd_data and ready are combinational from that state, so they show the new value in the cycle right after edge N. The eng_start, eng_suspend and eng_resume pulses are also high in that cycle and low in the next. The bench drives every input on the falling edge and checks each result on the falling edge that follows the next rising edge, so each check lands in the one cycle where the result is due. It sweeps every command byte from status mode, and every byte that can follow the erase setup code.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {RM_ARRAY, RM_IDENT, RM_STATUS} rmode_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_WSETUP, SQ_ESETUP} seq_e;
  typedef enum logic [1:0] {OP_NONE, OP_BWRITE, OP_ERASE} op_e;

  localparam logic [BYTE_W-1:0] CMD_RD_ARRAY = 8'hFF;
  localparam logic [BYTE_W-1:0] CMD_IDENT    = 8'h90;
  localparam logic [BYTE_W-1:0] CMD_RD_STAT  = 8'h70;
  localparam logic [BYTE_W-1:0] CMD_CLR_STAT = 8'h50;
  localparam logic [BYTE_W-1:0] CMD_ER_SETUP = 8'h20;
  localparam logic [BYTE_W-1:0] CMD_CONFIRM  = 8'hD0;
  localparam logic [BYTE_W-1:0] CMD_SUSPEND  = 8'hB0;
  localparam logic [BYTE_W-1:0] CMD_BW_SETUP = 8'h40;
  localparam logic [BYTE_W-1:0] CMD_BW_ALT   = 8'h10;

  // sticky field positions inside the 3-bit error vector
  localparam int STK_ER  = 2;
  localparam int STK_WR  = 1;
  localparam int STK_VPP = 0;
  localparam int STK_W   = 3;
endpackage

// File: rtl/fcd_status.sv
module fcd_status
  import fcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ready_i,
  input  logic              susp_i,
  input  logic              set_er_i,
  input  logic              set_wr_i,
  input  logic              set_vpp_i,
  input  logic              clr_i,
  output logic              vpp_lock_o,
  output logic [BYTE_W-1:0] status_o
);
  localparam int PAD_W = BYTE_W - 2 - STK_W;

  logic [STK_W-1:0] sticky_q;
  logic [STK_W-1:0] set_vec;

  always_comb begin
    set_vec          = '0;
    set_vec[STK_ER]  = set_er_i;
    set_vec[STK_WR]  = set_wr_i;
    set_vec[STK_VPP] = set_vpp_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sticky_q <= '0;
    else if (clr_i) sticky_q <= '0;
    else            sticky_q <= sticky_q | set_vec;
  end

  assign vpp_lock_o = sticky_q[STK_VPP];
  assign status_o   = {ready_i, susp_i, sticky_q, {PAD_W{1'b0}}};

  // R10
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

  // R10
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (sticky_q == '0));
endmodule

// File: rtl/fcd_rdmux.sv
module fcd_rdmux
  import fcd_pkg::*;
#(
  parameter int AW = 20,
  parameter logic [BYTE_W-1:0] ID_MFR = 8'h89,
  parameter logic [BYTE_W-1:0] ID_DEV = 8'hA2
)(
  input  rmode_e            rmode_i,
  input  logic [AW-1:0]     rd_addr_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  localparam logic [AW-1:0] ADDR_MFR = '0;
  localparam logic [AW-1:0] ADDR_DEV = AW'(1);

  logic [BYTE_W-1:0] id_byte;

  always_comb begin
    if (rd_addr_i == ADDR_MFR)      id_byte = ID_MFR;
    else if (rd_addr_i == ADDR_DEV) id_byte = ID_DEV;
    else                            id_byte = '0;
  end

  always_comb begin
    case (rmode_i)
      RM_IDENT:  rd_data_o = id_byte;
      RM_STATUS: rd_data_o = status_i;
      default:   rd_data_o = mem_rdata_i;
    endcase
    // R1
    if (rmode_i == RM_STATUS) begin
      status_pad_chk: assert (rd_data_o[2:0] == 3'b000);
    end
  end
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int AW = 20
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              vpp_ok_i,
  input  logic              vpp_lock_i,
  input  logic              eng_done_i,
  input  logic              eng_fail_i,
  input  logic              eng_susp_ack_i,
  output rmode_e            rmode_o,
  output logic              ready_o,
  output logic              susp_o,
  output logic              eng_start_o,
  output logic              eng_erase_o,
  output logic [AW-1:0]     eng_addr_o,
  output logic [BYTE_W-1:0] eng_wdata_o,
  output logic              eng_suspend_o,
  output logic              eng_resume_o,
  output logic              set_er_o,
  output logic              set_wr_o,
  output logic              set_vpp_o,
  output logic              clr_o
);
  rmode_e            rmode_q, rmode_n;
  seq_e              seq_q, seq_n;
  op_e               op_q, op_n;
  logic              susp_q, susp_n;
  logic              spend_q, spend_n;
  logic              start_q, start_n;
  logic              spulse_q, spulse_n;
  logic              resume_q, resume_n;
  logic              erase_q, erase_n;
  logic [AW-1:0]     addr_q, addr_n;
  logic [BYTE_W-1:0] wdata_q, wdata_n;
  logic              go, go_erase;

  always_comb begin
    rmode_n  = rmode_q;
    seq_n    = seq_q;
    op_n     = op_q;
    susp_n   = susp_q;
    spend_n  = spend_q;
    start_n  = 1'b0;
    spulse_n = 1'b0;
    resume_n = 1'b0;
    erase_n  = erase_q;
    addr_n   = addr_q;
    wdata_n  = wdata_q;
    set_er_o = 1'b0;
    set_wr_o = 1'b0;
    set_vpp_o = 1'b0;
    clr_o    = 1'b0;
    go       = 1'b0;
    go_erase = 1'b0;

    // engine feedback
    if (eng_done_i && op_q != OP_NONE) begin
      op_n    = OP_NONE;
      susp_n  = 1'b0;
      spend_n = 1'b0;
      if (eng_fail_i) begin
        if (op_q == OP_ERASE) set_er_o = 1'b1;
        else                  set_wr_o = 1'b1;
      end
    end
    if (eng_susp_ack_i && spend_q) begin
      susp_n  = 1'b1;
      spend_n = 1'b0;
    end

    // command decode
    if (wr_stb_i) begin
      case (seq_q)
        SQ_WSETUP: begin
          seq_n   = SQ_IDLE;
          rmode_n = RM_STATUS;
          go      = 1'b1;
        end
        SQ_ESETUP: begin
          seq_n   = SQ_IDLE;
          rmode_n = RM_STATUS;
          if (wr_data_i == CMD_CONFIRM) begin
            go       = 1'b1;
            go_erase = 1'b1;
          end else begin
            set_er_o = 1'b1;
            set_wr_o = 1'b1;
          end
        end
        default: begin
          if (op_q == OP_BWRITE) begin
            if (wr_data_i == CMD_RD_STAT) rmode_n = RM_STATUS;
          end else if (op_q == OP_ERASE && !susp_q) begin
            if (wr_data_i == CMD_RD_STAT) begin
              rmode_n = RM_STATUS;
            end else if (wr_data_i == CMD_SUSPEND && !spend_q) begin
              spend_n  = 1'b1;
              spulse_n = 1'b1;
              rmode_n  = RM_STATUS;
            end
          end else if (susp_q) begin
            case (wr_data_i)
              CMD_RD_ARRAY: rmode_n = RM_ARRAY;
              CMD_RD_STAT:  rmode_n = RM_STATUS;
              CMD_CONFIRM: begin
                resume_n = 1'b1;
                susp_n   = 1'b0;
                rmode_n  = RM_STATUS;
              end
              default: ;
            endcase
          end else begin
            case (wr_data_i)
              CMD_RD_ARRAY: rmode_n = RM_ARRAY;
              CMD_IDENT:    rmode_n = RM_IDENT;
              CMD_RD_STAT:  rmode_n = RM_STATUS;
              CMD_CLR_STAT: clr_o   = 1'b1;
              CMD_ER_SETUP: seq_n   = SQ_ESETUP;
              CMD_BW_SETUP: seq_n   = SQ_WSETUP;
              CMD_BW_ALT:   seq_n   = SQ_WSETUP;
              default: ;
            endcase
          end
        end
      endcase
    end

    // start gate: supply lock refuses, low supply flags and refuses
    if (go && !vpp_lock_i) begin
      if (!vpp_ok_i) begin
        set_vpp_o = 1'b1;
      end else begin
        start_n = 1'b1;
        op_n    = go_erase ? OP_ERASE : OP_BWRITE;
        erase_n = go_erase;
        addr_n  = wr_addr_i;
        wdata_n = wr_data_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rmode_q  <= RM_ARRAY;
      seq_q    <= SQ_IDLE;
      op_q     <= OP_NONE;
      susp_q   <= 1'b0;
      spend_q  <= 1'b0;
      start_q  <= 1'b0;
      spulse_q <= 1'b0;
      resume_q <= 1'b0;
      erase_q  <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else begin
      rmode_q  <= rmode_n;
      seq_q    <= seq_n;
      op_q     <= op_n;
      susp_q   <= susp_n;
      spend_q  <= spend_n;
      start_q  <= start_n;
      spulse_q <= spulse_n;
      resume_q <= resume_n;
      erase_q  <= erase_n;
      addr_q   <= addr_n;
      wdata_q  <= wdata_n;
    end
  end

  assign rmode_o       = rmode_q;
  assign ready_o       = (op_q == OP_NONE) || susp_q;
  assign susp_o        = susp_q;
  assign eng_start_o   = start_q;
  assign eng_erase_o   = erase_q;
  assign eng_addr_o    = addr_q;
  assign eng_wdata_o   = wdata_q;
  assign eng_suspend_o = spulse_q;
  assign eng_resume_o  = resume_q;

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |=> !eng_start_o);

  // R7
  susp_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_suspend_o |-> (op_q == OP_ERASE));

  // R8
  susp_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    susp_q |-> (op_q == OP_ERASE && !spend_q));

  // R11
  vpp_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_lock_i && wr_stb_i && seq_q != SQ_IDLE) |=> !eng_start_o);

  // R13
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |-> !ready_o);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int AW = 20,
  parameter logic [7:0] ID_MFR = 8'h89,
  parameter logic [7:0] ID_DEV = 8'hA2
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic [7:0]    mem_rdata,
  input  logic          vpp_ok,
  output logic          ready,
  output logic          eng_start,
  output logic          eng_erase,
  output logic [AW-1:0] eng_addr,
  output logic [7:0]    eng_wdata,
  output logic          eng_suspend,
  output logic          eng_resume,
  input  logic          eng_done,
  input  logic          eng_fail,
  input  logic          eng_susp_ack
);
  rmode_e            rmode;
  logic              susp;
  logic              set_er, set_wr, set_vpp, clr;
  logic              vpp_lock;
  logic [BYTE_W-1:0] status;

  fcd_seq #(.AW(AW)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_stb_i       (wr_stb),
    .wr_addr_i      (wr_addr),
    .wr_data_i      (wr_data),
    .vpp_ok_i       (vpp_ok),
    .vpp_lock_i     (vpp_lock),
    .eng_done_i     (eng_done),
    .eng_fail_i     (eng_fail),
    .eng_susp_ack_i (eng_susp_ack),
    .rmode_o        (rmode),
    .ready_o        (ready),
    .susp_o         (susp),
    .eng_start_o    (eng_start),
    .eng_erase_o    (eng_erase),
    .eng_addr_o     (eng_addr),
    .eng_wdata_o    (eng_wdata),
    .eng_suspend_o  (eng_suspend),
    .eng_resume_o   (eng_resume),
    .set_er_o       (set_er),
    .set_wr_o       (set_wr),
    .set_vpp_o      (set_vpp),
    .clr_o          (clr)
  );

  fcd_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready_i    (ready),
    .susp_i     (susp),
    .set_er_i   (set_er),
    .set_wr_i   (set_wr),
    .set_vpp_i  (set_vpp),
    .clr_i      (clr),
    .vpp_lock_o (vpp_lock),
    .status_o   (status)
  );

  fcd_rdmux #(.AW(AW), .ID_MFR(ID_MFR), .ID_DEV(ID_DEV)) u_rdmux (
    .rmode_i     (rmode),
    .rd_addr_i   (rd_addr),
    .mem_rdata_i (mem_rdata),
    .status_i    (status),
    .rd_data_o   (rd_data)
  );
endmodule

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;
  localparam int AW = 4;
  localparam logic [7:0] MEMB = 8'h5C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_stb = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic [7:0]    mem_rdata = MEMB;
  logic          vpp_ok = 1'b1;
  logic          ready;
  logic          eng_start, eng_erase, eng_suspend, eng_resume;
  logic [AW-1:0] eng_addr;
  logic [7:0]    eng_wdata;
  logic          eng_done = 1'b0, eng_fail = 1'b0, eng_susp_ack = 1'b0;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder #(.AW(AW)) i_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .mem_rdata(mem_rdata), .vpp_ok(vpp_ok),
    .ready(ready), .eng_start(eng_start), .eng_erase(eng_erase), .eng_addr(eng_addr),
    .eng_wdata(eng_wdata), .eng_suspend(eng_suspend), .eng_resume(eng_resume),
    .eng_done(eng_done), .eng_fail(eng_fail), .eng_susp_ack(eng_susp_ack)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_stb = 1'b0; eng_done = 1'b0; eng_susp_ack = 1'b0;
    vpp_ok = 1'b1; rd_addr = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // strobe is sampled at the next rising edge; returns one falling edge later
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic done(input logic f);
    eng_done = 1'b1; eng_fail = f;
    @(negedge clk);
    eng_done = 1'b0; eng_fail = 1'b0;
  endtask

  task automatic sack();
    eng_susp_ack = 1'b1;
    @(negedge clk);
    eng_susp_ack = 1'b0;
  endtask

  function automatic logic [7:0] exp_from_status(input logic [7:0] c);
    case (c)
      8'hFF:   return MEMB;
      8'h90:   return 8'h89;
      default: return 8'h80;
    endcase
  endfunction

  initial begin
    do_reset();
    @(negedge clk);
    // R1 reset: array mode, ready, status 80h
    chk("R1 array after reset", rd_data, MEMB);
    chk("R1 ready", {7'b0, ready}, 8'h01);
    wr(0, 8'h70);
    chk("R1 status 80h", rd_data, 8'h80);
    wr(0, 8'hFF);
    chk("R2 FF array", rd_data, MEMB);
    mem_rdata = 8'h3A;
    #0.1;
    chk("R2 array follows mem", rd_data, 8'h3A);
    mem_rdata = MEMB;

    // R3 identifier address sweep
    wr(0, 8'h90);
    for (int a = 0; a < (1 << AW); a++) begin
      rd_addr = AW'(a);
      #0.1;
      chk("R3 ident", rd_data, (a == 0) ? 8'h89 : (a == 1) ? 8'hA2 : 8'h00);
    end
    rd_addr = '0;

    // sweep of every command byte from status mode (R2, R12, R4, R5)
    for (int c = 0; c < 256; c++) begin
      do_reset();
      wr(0, 8'h70);
      wr(1, 8'(c));
      chk((c == 8'hFF || c == 8'h70 || c == 8'h90) ? "R2 code route" : "R12 code keeps mode",
          rd_data, exp_from_status(8'(c)));
      chk("R12 no start on first cycle", {7'b0, eng_start}, 8'h00);
      if (c == 8'h20) begin
        wr(3, 8'hFF);
        chk("R5 bad sequence status", rd_data, 8'hB0);
        chk("R5 bad sequence no start", {7'b0, eng_start}, 8'h00);
      end else if (c == 8'h40 || c == 8'h10) begin
        wr(3, 8'hFF);
        chk("R4 start", {7'b0, eng_start}, 8'h01);
        chk("R4 status busy", rd_data, 8'h00);
      end
    end

    // sweep every byte following erase setup (R5)
    for (int c = 0; c < 256; c++) begin
      do_reset();
      wr(2, 8'h20);
      wr(6, 8'(c));
      if (c == 8'hD0) begin
        chk("R5 erase start", {6'b0, eng_start, eng_erase}, 8'h03);
        chk("R5 erase addr", {4'b0, eng_addr}, 8'h06);
        chk("R5 erase status", rd_data, 8'h00);
      end else begin
        chk("R5 non-confirm status", rd_data, 8'hB0);
        chk("R5 non-confirm no start", {7'b0, eng_start}, 8'h00);
      end
    end

    // byte write details and running restriction
    do_reset();
    wr(5, 8'h40);
    wr(9, 8'h3C);
    chk("R4 start pulse", {6'b0, eng_start, eng_erase}, 8'h02);
    chk("R4 addr", {4'b0, eng_addr}, 8'h09);
    chk("R4 wdata", eng_wdata, 8'h3C);
    chk("R13 busy", {7'b0, ready}, 8'h00);
    @(negedge clk);
    chk("R4 pulse one cycle", {7'b0, eng_start}, 8'h00);
    wr(0, 8'hFF);
    chk("R6 FF ignored", rd_data, 8'h00);
    wr(0, 8'h90);
    chk("R6 90 ignored", rd_data, 8'h00);
    wr(0, 8'h50);
    chk("R6 50 ignored", rd_data, 8'h00);
    done(1'b1);
    chk("R9 write fail", rd_data, 8'h90);
    chk("R13 ready after done", {7'b0, ready}, 8'h01);

    // R10 sticky through another good op, then clear
    wr(1, 8'h10);
    wr(2, 8'h11);
    chk("R10 start with stale error", {7'b0, eng_start}, 8'h01);
    done(1'b0);
    chk("R10 sticky kept", rd_data, 8'h90);
    wr(0, 8'hFF);
    wr(0, 8'h70);
    chk("R10 sticky after commands", rd_data, 8'h90);
    wr(0, 8'h50);
    chk("R10 clear", rd_data, 8'h80);

    // R11 supply low and lockout
    vpp_ok = 1'b0;
    wr(1, 8'h40);
    wr(1, 8'h77);
    chk("R11 low supply no start", {7'b0, eng_start}, 8'h00);
    chk("R11 supply bit", rd_data, 8'h88);
    vpp_ok = 1'b1;
    wr(2, 8'h20);
    wr(2, 8'hD0);
    chk("R11 locked refuse", {7'b0, eng_start}, 8'h00);
    chk("R11 still flagged", rd_data, 8'h88);
    wr(0, 8'h50);
    chk("R11 cleared", rd_data, 8'h80);

    // erase, suspend, resume
    wr(4, 8'h20);
    wr(4, 8'hD0);
    chk("R5 erase launch", {6'b0, eng_start, eng_erase}, 8'h03);
    wr(0, 8'hFF);
    chk("R7 FF ignored", rd_data, 8'h00);
    wr(0, 8'h90);
    chk("R7 90 ignored", rd_data, 8'h00);
    wr(0, 8'hB0);
    chk("R7 suspend pulse", {7'b0, eng_suspend}, 8'h01);
    chk("R13 pending busy", {7'b0, ready}, 8'h00);
    @(negedge clk);
    chk("R7 suspend one cycle", {7'b0, eng_suspend}, 8'h00);
    sack();
    chk("R7 suspended status", rd_data, 8'hC0);
    chk("R13 ready when suspended", {7'b0, ready}, 8'h01);
    wr(0, 8'hFF);
    chk("R8 FF while suspended", rd_data, MEMB);
    wr(0, 8'h90);
    chk("R8 90 ignored", rd_data, MEMB);
    wr(0, 8'h70);
    chk("R8 70 while suspended", rd_data, 8'hC0);
    wr(0, 8'hD0);
    chk("R8 resume pulse", {7'b0, eng_resume}, 8'h01);
    chk("R8 resumed status", rd_data, 8'h00);
    done(1'b1);
    chk("R9 erase fail", rd_data, 8'hA0);
    wr(0, 8'h50);
    chk("R10 clear erase error", rd_data, 8'h80);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule